// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates a 32-bit virtual address into a physical address for 4 KiB pages. It holds a small set of translations, each tagged with an address-space identifier so that mappings for several processes can stay resident at once. Every lookup compares the virtual page number and the current identifier against all valid entries in parallel. On a hit, the stored physical page number replaces the upper address bits, and the 12 in-page offset bits pass through unchanged. The matching entry's read, write and cacheable attributes come out with the translation.

Lookups are purely combinational, from request to hit, physical address, cacheable and fault outputs. Entries are loaded through a single-cycle write port, and the block chooses the slot itself. If the key is already present, that slot is overwritten. Otherwise the lowest-numbered empty slot is used. When every slot is full, a round-robin victim is replaced. Two flush controls are provided: one clears the whole table, and the other clears only the entries of one identifier. Refill from memory and fault handling belong to the surrounding logic. The block only reports a miss or a permission fault.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `lk_paddr[31:12]` equals the stored physical page number and `lk_paddr[11:0]` equals `lk_vaddr[11:0]`.
- R2: An entry hits only if it is valid, its page number equals `lk_vaddr[31:12]` and its identifier equals `lk_asid`. Otherwise `lk_hit`, `lk_paddr`, `lk_cacheable` and `lk_fault` are all zero.
- R3: The attribute field `wr_attr` is encoded as bit 0 readable, bit 1 writable and bit 2 cacheable. On a hit, `lk_cacheable` equals the stored bit 2.
- R4: `lk_fault` is 1 when a load (`lk_store`=0) hits an entry whose readable bit is 0, or when a store (`lk_store`=1) hits an entry whose writable bit is 0. It is 0 in every other case.
- R5: Lookup outputs follow the lookup inputs in the same cycle. A write that is accepted at a clock edge is visible to lookups after that edge.
- R6: A write whose page number and identifier match a valid entry overwrites that entry. No other entry changes.
- R7: A write whose key is not present goes into the lowest-numbered invalid slot.
- R8: When all slots are valid and the key is not present, the write replaces the slot named by a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping after 15) only on such a replacement, and is not cleared by flushes.
- R9: `flush_all` invalidates every entry at the clock edge.
- R10: `flush_asid_en` invalidates exactly the entries whose identifier equals `flush_asid`.
- R11: A write in the same cycle as either flush is discarded.
- R12: After reset, every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Identifier of the requesting address space |
| lk_store | input | 1 | 1 for a store access, 0 for a load |
| lk_hit | output | 1 | A valid entry matches |
| lk_paddr | output | 32 | Translated physical address, zero on a miss |
| lk_cacheable | output | 1 | Cacheable attribute of the hit entry |
| lk_fault | output | 1 | Permission fault on a hit |
| wr_en | input | 1 | Load an entry |
| wr_vpn | input | 20 | Virtual page number to load |
| wr_asid | input | 8 | Identifier to load |
| wr_ppn | input | 20 | Physical page number to load |
| wr_attr | input | 3 | Attributes: bit 0 readable, bit 1 writable, bit 2 cacheable |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the entries of one identifier |
| flush_asid | input | 8 | Identifier for the selective flush |

## Verification
Directed sequences fill the table from empty, then force two round-robin evictions. They also rewrite a key that is already present, open holes with a selective flush and fill them again, and collide a write with a flush. These sequences separate the three slot-selection paths, because each wrong choice evicts a different surviving key. Identical page numbers with different identifiers separate the identifier compare from the page compare. Loads and stores against entries with mixed attributes separate the read-fault case from the write-fault case. Random traffic from a small pool of keys and identifiers produces frequent hits, overwrites, evictions and flushes, and every lookup is compared against a reference table kept in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef struct packed {
        logic cach;
        logic wr;
        logic rd;
    } tlb_attr_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_go,
    input  logic [IDX_W-1:0]   wr_slot,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  tlb_attr_t          wr_attr,
    input  logic               flush_all,
    input  logic               flush_asid_en,
    input  logic [ASID_W-1:0]  flush_asid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic [ENTRIES-1:0] valid_o,
    output logic [ENTRIES-1:0] lk_match,
    output logic [ENTRIES-1:0] wk_match,
    output logic [PPN_W-1:0]   lk_ppn,
    output tlb_attr_t          lk_attr
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    tlb_attr_t          attr_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                asid_q[i] <= '0;
                ppn_q[i]  <= '0;
                attr_q[i] <= '0;
            end
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++)
                if (asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
        end else if (wr_go) begin
            valid_q[wr_slot] <= 1'b1;
            vpn_q[wr_slot]   <= wr_vpn;
            asid_q[wr_slot]  <= wr_asid;
            ppn_q[wr_slot]   <= wr_ppn;
            attr_q[wr_slot]  <= wr_attr;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && vpn_q[g] == lk_vpn && asid_q[g] == lk_asid;
        assign wk_match[g] = valid_q[g] && vpn_q[g] == wr_vpn && asid_q[g] == wr_asid;
    end

    always_comb begin
        lk_ppn  = '0;
        lk_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_ppn  = lk_ppn | ppn_q[i];
                lk_attr = tlb_attr_t'(lk_attr | attr_q[i]);
            end
        end
    end

    assign valid_o = valid_q;

    // R6
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R9
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !flush_all && !flush_asid_en) |=> valid_q[$past(wr_slot)]);
endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_go,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] wk_match,
    output logic [IDX_W-1:0]   slot
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;
    logic             key_seen;
    logic             full;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (wk_match[i]) hit_idx  = IDX_W'(i);
            if (!valid[i])   free_idx = IDX_W'(i);
        end
    end

    assign key_seen = |wk_match;
    assign full     = &valid;

    always_comb begin
        if (key_seen)   slot = hit_idx;
        else if (!full) slot = free_idx;
        else            slot = rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (wr_go && !key_seen && full) begin
            if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
            else                             rr_q <= rr_q + 1'b1;
        end
    end

    // R7
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !key_seen && !full) |-> !valid[slot]);

    // R6
    rewrite_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && key_seen) |-> wk_match[slot]);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PG_W    = 12,
    parameter int ASID_W  = 8,
    localparam int VPN_W  = VA_W - PG_W,
    localparam int PPN_W  = PA_W - PG_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_cacheable,
    output logic              lk_fault,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [2:0]        wr_attr,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wk_match;
    logic [PPN_W-1:0]   hit_ppn;
    tlb_attr_t          hit_attr;
    logic [IDX_W-1:0]   slot;
    logic               wr_go;

    assign wr_go = wr_en && !flush_all && !flush_asid_en;

    tlb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .valid    (valid),
        .wk_match (wk_match),
        .slot     (slot)
    );

    tlb_cam #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
    ) u_cam (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_go         (wr_go),
        .wr_slot       (slot),
        .wr_vpn        (wr_vpn),
        .wr_asid       (wr_asid),
        .wr_ppn        (wr_ppn),
        .wr_attr       (tlb_attr_t'(wr_attr)),
        .flush_all     (flush_all),
        .flush_asid_en (flush_asid_en),
        .flush_asid    (flush_asid),
        .lk_vpn        (lk_vaddr[VA_W-1:PG_W]),
        .lk_asid       (lk_asid),
        .valid_o       (valid),
        .lk_match      (lk_match),
        .wk_match      (wk_match),
        .lk_ppn        (hit_ppn),
        .lk_attr       (hit_attr)
    );

    always_comb begin
        lk_hit       = |lk_match;
        lk_paddr     = '0;
        lk_cacheable = 1'b0;
        lk_fault     = 1'b0;
        if (lk_hit) begin
            lk_paddr     = {hit_ppn, lk_vaddr[PG_W-1:0]};
            lk_cacheable = hit_attr.cach;
            lk_fault     = lk_store ? !hit_attr.wr : !hit_attr.rd;
        end
    end

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[PG_W-1:0] == lk_vaddr[PG_W-1:0]));

    // R2
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && !lk_fault && !lk_cacheable));

    // R10
    asid_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_asid_en && !flush_all && lk_asid == flush_asid) |=>
            (!lk_hit || $changed(lk_asid) || $changed(lk_vaddr)));
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        lk_store;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        lk_cacheable;
    logic        lk_fault;
    logic        wr_en;
    logic [19:0] wr_vpn;
    logic [7:0]  wr_asid;
    logic [19:0] wr_ppn;
    logic [2:0]  wr_attr;
    logic        flush_all;
    logic        flush_asid_en;
    logic [7:0]  flush_asid;

    always #5 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_store(lk_store), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .lk_cacheable(lk_cacheable), .lk_fault(lk_fault), .wr_en(wr_en),
        .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_attr(wr_attr),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    bit          m_v    [N];
    logic [19:0] m_vpn  [N];
    logic [7:0]  m_asid [N];
    logic [19:0] m_ppn  [N];
    logic [2:0]  m_attr [N];
    int          m_rr;
    int          vecs;
    int          errs;

    function automatic int find(input logic [19:0] vpn, input logic [7:0] asid);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic int pick(input logic [19:0] vpn, input logic [7:0] asid);
        int k;
        k = find(vpn, asid);
        if (k >= 0) return k;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -2;
    endfunction

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual hit/cach/fault/pa=%h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check lookup, then update model at posedge
    task automatic cyc(input bit we, input logic [19:0] vpn, input logic [7:0] asid,
                       input logic [19:0] ppn, input logic [2:0] attr,
                       input bit fa, input bit fe, input logic [7:0] fas,
                       input logic [31:0] va, input logic [7:0] la, input bit st,
                       input string req);
        int k;
        logic [34:0] exp;
        @(negedge clk);
        wr_en = we; wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn; wr_attr = attr;
        flush_all = fa; flush_asid_en = fe; flush_asid = fas;
        lk_vaddr = va; lk_asid = la; lk_store = st;
        #1;
        k = find(va[31:12], la);
        if (k < 0) exp = '0;
        else exp = {1'b1, m_attr[k][2], st ? !m_attr[k][1] : !m_attr[k][0],
                    m_ppn[k], va[11:0]};
        check(req, {lk_hit, lk_cacheable, lk_fault, lk_paddr}, exp);
        @(posedge clk);
        if (fa) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (fe) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == fas) m_v[i] = 1'b0;
        end else if (we) begin
            k = pick(vpn, asid);
            if (k == -2) begin
                k = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[k] = 1'b1; m_vpn[k] = vpn; m_asid[k] = asid;
            m_ppn[k] = ppn; m_attr[k] = attr;
        end
    endtask

    task automatic wr(input logic [19:0] vpn, input logic [7:0] asid,
                      input logic [19:0] ppn, input logic [2:0] attr);
        cyc(1, vpn, asid, ppn, attr, 0, 0, 0, 32'h0, 8'hff, 0, "R5");
    endtask

    task automatic look(input logic [19:0] vpn, input logic [7:0] asid,
                        input bit st, input string req);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, {vpn, 12'($urandom)}, asid, st, req);
    endtask

    initial begin
        #2000000;
        errs++;
        $display("FAIL R5 watchdog: actual hung, expected finished run");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        vecs = 0; errs = 0; m_rr = 0;
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        rst_n = 1'b0;
        wr_en = 0; wr_vpn = 0; wr_asid = 0; wr_ppn = 0; wr_attr = 0;
        flush_all = 0; flush_asid_en = 0; flush_asid = 0;
        lk_vaddr = 0; lk_asid = 0; lk_store = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        look(20'h0, 8'h0, 0, "R12");
        look(20'h105, 8'h1, 1, "R12");

        // fill from empty, attributes vary per slot
        for (int i = 0; i < N; i++) wr(20'h100 + 20'(i), 8'h1, 20'h800 + 20'(i), 3'(i));
        for (int i = 0; i < N; i++) look(20'h100 + 20'(i), 8'h1, i[0], "R1");
        look(20'h103, 8'h2, 0, "R2");
        look(20'h1ff, 8'h1, 0, "R2");

        // round-robin evictions of slots 0 and 1
        wr(20'h200, 8'h1, 20'h900, 3'b111);
        look(20'h100, 8'h1, 0, "R8");
        look(20'h200, 8'h1, 0, "R8");
        wr(20'h201, 8'h1, 20'h901, 3'b111);
        look(20'h101, 8'h1, 0, "R8");
        look(20'h102, 8'h1, 0, "R8");

        // rewrite of a present key evicts nothing
        wr(20'h105, 8'h1, 20'habc, 3'b101);
        look(20'h105, 8'h1, 0, "R6");
        look(20'h102, 8'h1, 0, "R6");
        look(20'h203, 8'h1, 0, "R6");

        // holes from a selective flush are refilled lowest first
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 32'h0, 8'h0, 0, "R9");
        look(20'h200, 8'h1, 0, "R9");
        for (int i = 0; i < N; i++)
            wr(20'h300 + 20'(i), (i == 3 || i == 9) ? 8'h2 : 8'h1, 20'h400 + 20'(i), 3'b011);
        cyc(0, 0, 0, 0, 0, 0, 1, 8'h2, {20'h303, 12'h0}, 8'h2, 0, "R10");
        look(20'h303, 8'h2, 0, "R10");
        look(20'h309, 8'h2, 0, "R10");
        look(20'h304, 8'h1, 0, "R10");
        wr(20'h350, 8'h1, 20'h550, 3'b111);
        wr(20'h351, 8'h1, 20'h551, 3'b111);
        for (int i = 0; i < N; i++) look(20'h300 + 20'(i), 8'h1, 0, "R7");
        wr(20'h352, 8'h1, 20'h552, 3'b111);
        look(20'h302, 8'h1, 0, "R8");
        look(20'h352, 8'h1, 0, "R8");

        // write colliding with flushes is discarded
        cyc(1, 20'h777, 8'h3, 20'h111, 3'b111, 1, 0, 0, 32'h0, 8'h0, 0, "R11");
        look(20'h777, 8'h3, 0, "R11");
        cyc(1, 20'h778, 8'h3, 20'h111, 3'b111, 0, 1, 8'h9, 32'h0, 8'h0, 0, "R11");
        look(20'h778, 8'h3, 0, "R11");

        // permissions and cacheable
        wr(20'h010, 8'h5, 20'h0aa, 3'b010);
        wr(20'h011, 8'h5, 20'h0bb, 3'b101);
        look(20'h010, 8'h5, 0, "R4");
        look(20'h010, 8'h5, 1, "R4");
        look(20'h011, 8'h5, 1, "R4");
        look(20'h011, 8'h5, 0, "R3");

        // random traffic over a small key pool
        for (int n = 0; n < 6000; n++) begin
            int r;
            logic [19:0] lv;
            logic [7:0]  la;
            string tag;
            r  = int'($urandom % 100);
            lv = 20'($urandom % 24);
            la = 8'($urandom % 3);
            tag = (find(lv, la) < 0) ? "R2" : "R1";
            cyc(r < 45, 20'($urandom % 24), 8'($urandom % 3), 20'($urandom), 3'($urandom),
                r == 99, r >= 95 && r < 99, 8'($urandom % 3),
                {lv, 12'($urandom)}, la, 1'($urandom), tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule